// File: doc/BRIEF.md
# Register Mirror with Sticky Edge Flags

This block returns a host's control settings to it. A host writes a bank of control registers, and each one reappears in a read-back register of the same index after exactly one clock stage. The read-back bank gives software a registered, glitch-free view of what it wrote, aligned to the system clock.

One slot is special. In the flag slot, the two lowest read-back bits do not copy the written bits. They hold two sticky flags: one latches a rising edge of a monitored violation signal and the other latches a falling edge. Each flag stays set until the host writes a 1 to the bit at the same position in the flag slot's write register. The upper bits of that slot are mirrored like every other slot. The violation signal must already be synchronous to the clock.

Top module: `reg_mirror_sticky`

## Requirements
- R1: For every slot other than the flag slot (slot 14 by default), rdRegs[i] equals the value wrRegs[i] had at the previous rising clock edge, with one cycle of latency.
- R2: The rising-edge flag, rdRegs[14] bit 0, becomes 1 in the cycle after violIn is sampled 1 when it was sampled 0 at the edge before. With no clear it then stays 1, whatever violIn does afterwards.
- R3: The falling-edge flag, rdRegs[14] bit 1, becomes 1 in the cycle after violIn is sampled 0 when it was sampled 1 at the edge before. With no clear it stays 1.
- R4: When wrRegs[14] bit 0 is sampled 1, the rising-edge flag reads 0 in the next cycle. When wrRegs[14] bit 1 is sampled 1, the falling-edge flag reads 0 in the next cycle. A clear bit has no effect on the other flag.
- R5: rdRegs[14] bits 15:2 equal wrRegs[14] bits 15:2 from the previous edge.
- R6: If a clear bit and a new edge of the matching polarity are sampled at the same edge, the flag reads 1 in the next cycle.
- R7: While rstN is 0, all read-back bits are 0, taking effect without waiting for a clock edge. The edge history also resets to 0, so a violIn that is 1 at reset release sets the rising-edge flag one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrRegs | input | 16x16 | Host-written control registers, packed, slot i at [i] |
| violIn | input | 1 | Monitored violation signal, synchronous to clk |
| rdRegs | output | 16x16 | Read-back registers, packed, slot i at [i] |

## Verification
The mirror path is driven with random words in every slot and with a walking single 1 across all bit positions. The walking 1 separates a true one-stage copy from a copy that is swapped between slots, truncated or delayed. The violation input is held high, held low and toggled every cycle, so a level-sensitive flag can be told apart from an edge-sensitive one and a flag that is not sticky is exposed. Clears are issued alone, held over several cycles, and in the same cycle as an edge of each polarity. The collision cases show whether set has priority over clear and whether each clear reaches only its own flag. A reset in the middle of a run, taken with violIn high, checks that the edge history returns to zero.

// File: rtl/reg_mirror_pkg.sv
`timescale 1ns/1ps
package reg_mirror_pkg;
  localparam int RISE_BIT = 0;
  localparam int FALL_BIT = 1;

  typedef struct packed {
    logic setRise;
    logic setFall;
    logic clrRise;
    logic clrFall;
  } edgeStrb_t;
endpackage

// File: rtl/edge_flag_ctrl.sv
`timescale 1ns/1ps
module edge_flag_ctrl
  import reg_mirror_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      violIn,
  input  logic [1:0] clrBits,
  output edgeStrb_t strb
);
  logic violPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) violPrev <= 1'b0;
    else       violPrev <= violIn;
  end

  always_comb begin
    strb.setRise = violIn & ~violPrev;
    strb.setFall = ~violIn & violPrev;
    strb.clrRise = clrBits[RISE_BIT];
    strb.clrFall = clrBits[FALL_BIT];
  end
endmodule

// File: rtl/mirror_datapath.sv
`timescale 1ns/1ps
module mirror_datapath
  import reg_mirror_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int REG_W     = 16,
  parameter int FLAG_SLOT = 14
)(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_REGS-1:0][REG_W-1:0] wrRegs,
  input  edgeStrb_t                      strb,
  output logic [NUM_REGS-1:0][REG_W-1:0] rdRegs
);
  localparam int FLAG_W = 2;

  logic [NUM_REGS-1:0][REG_W-1:0] nextVal;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSlot
    if (g == FLAG_SLOT) begin : gFlag
      assign nextVal[g][REG_W-1:FLAG_W] = wrRegs[g][REG_W-1:FLAG_W];
      assign nextVal[g][RISE_BIT] = strb.setRise | (rdRegs[g][RISE_BIT] & ~strb.clrRise);
      assign nextVal[g][FALL_BIT] = strb.setFall | (rdRegs[g][FALL_BIT] & ~strb.clrFall);
    end else begin : gPlain
      assign nextVal[g] = wrRegs[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdRegs <= '0;
    else       rdRegs <= nextVal;
  end
endmodule

// File: rtl/reg_mirror_sticky.sv
`timescale 1ns/1ps
module reg_mirror_sticky
  import reg_mirror_pkg::*;
#(
  parameter int NUM_REGS  = 16,
  parameter int REG_W     = 16,
  parameter int FLAG_SLOT = 14
)(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_REGS-1:0][REG_W-1:0] wrRegs,
  input  logic                           violIn,
  output logic [NUM_REGS-1:0][REG_W-1:0] rdRegs
);
  edgeStrb_t strb;

  edge_flag_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .violIn  (violIn),
    .clrBits (wrRegs[FLAG_SLOT][1:0]),
    .strb    (strb)
  );

  mirror_datapath #(
    .NUM_REGS  (NUM_REGS),
    .REG_W     (REG_W),
    .FLAG_SLOT (FLAG_SLOT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .wrRegs (wrRegs),
    .strb   (strb),
    .rdRegs (rdRegs)
  );
endmodule

// File: rtl/reg_mirror_sticky_chk.sv
`timescale 1ns/1ps
module reg_mirror_sticky_chk #(
  parameter int NUM_REGS  = 16,
  parameter int REG_W     = 16,
  parameter int FLAG_SLOT = 14
)(
  input logic                           clk,
  input logic                           rstN,
  input logic [NUM_REGS-1:0][REG_W-1:0] wrRegs,
  input logic                           violIn,
  input logic [NUM_REGS-1:0][REG_W-1:0] rdRegs
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : gChk
    if (g != FLAG_SLOT) begin : gPlain
      AST_MIRROR_SLOT: assert property (@(posedge clk) disable iff (!rstN)
        rstN |=> rdRegs[g] == $past(wrRegs[g])); // R1
    end
  end

  AST_UPPER_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> rdRegs[FLAG_SLOT][REG_W-1:2] == $past(wrRegs[FLAG_SLOT][REG_W-1:2])); // R5

  AST_RISE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && $past(rstN) && violIn && !$past(violIn)) |=> rdRegs[FLAG_SLOT][0]); // R2

  AST_FALL_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && $past(rstN) && !violIn && $past(violIn)) |=> rdRegs[FLAG_SLOT][1]); // R3

  AST_RISE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && $past(rstN) && wrRegs[FLAG_SLOT][0] && !(violIn && !$past(violIn)))
      |=> !rdRegs[FLAG_SLOT][0]); // R4

  AST_FALL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && $past(rstN) && wrRegs[FLAG_SLOT][1] && !(!violIn && $past(violIn)))
      |=> !rdRegs[FLAG_SLOT][1]); // R4

  AST_RISE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && $past(rstN) && !wrRegs[FLAG_SLOT][0] && rdRegs[FLAG_SLOT][0])
      |=> rdRegs[FLAG_SLOT][0]); // R2
endmodule

bind reg_mirror_sticky reg_mirror_sticky_chk #(
  .NUM_REGS  (NUM_REGS),
  .REG_W     (REG_W),
  .FLAG_SLOT (FLAG_SLOT)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrRegs (wrRegs),
  .violIn (violIn),
  .rdRegs (rdRegs)
);

// File: tb/reg_mirror_sticky_tb.sv
`timescale 1ns/1ps
module reg_mirror_sticky_tb;
  localparam int N = 16;
  localparam int W = 16;
  localparam int S = 14;

  logic clk = 1'b0;
  logic rstN;
  logic [N-1:0][W-1:0] wrRegs;
  logic violIn;
  logic [N-1:0][W-1:0] rdRegs;

  int tests = 0;
  int fails = 0;
  string riseTag = "R2";
  string fallTag = "R3";
  bit inReset = 1'b0;

  always #10 clk = ~clk;

  reg_mirror_sticky u_dut (
    .clk(clk), .rstN(rstN), .wrRegs(wrRegs), .violIn(violIn), .rdRegs(rdRegs)
  );

  // behavioural reference
  int mdl [N];
  bit mRise, mFall, mPrev;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) mdl[i] = 0;
      mRise = 0; mFall = 0; mPrev = 0;
    end else begin
      for (int i = 0; i < N; i++) mdl[i] = int'(wrRegs[i]);
      if (violIn && !mPrev)      mRise = 1;
      else if (wrRegs[S][0])     mRise = 0;
      if (!violIn && mPrev)      mFall = 1;
      else if (wrRegs[S][1])     mFall = 0;
      mPrev = violIn;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    for (int i = 0; i < N; i++) begin
      if (i == S) begin
        chk(inReset ? "R7" : "R5", int'(rdRegs[S][W-1:2]), mdl[S] >> 2);
        chk(inReset ? "R7" : riseTag, int'(rdRegs[S][0]), int'(mRise));
        chk(inReset ? "R7" : fallTag, int'(rdRegs[S][1]), int'(mFall));
      end else begin
        chk(inReset ? "R7" : "R1", int'(rdRegs[i]), mdl[i] & 16'hFFFF);
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrRegs = '0; violIn = 1'b0;
    inReset = 1'b1;
    wrRegs[3] = 16'hBEEF;
    repeat (3) step();
    chk("R7", int'(rdRegs[3]), 0);
    inReset = 1'b0;
    rstN = 1'b1;
    // R1 R5: random words
    for (int c = 0; c < 40; c++) begin
      for (int i = 0; i < N; i++) wrRegs[i] = 16'($urandom);
      step();
    end
    // R1: walking one across all bits
    for (int b = 0; b < W; b++) begin
      for (int i = 0; i < N; i++) wrRegs[i] = 16'(1 << ((b + i) % W));
      step();
      chk("R1", int'(rdRegs[0]), 1 << b);
    end
    wrRegs = '0; step(); step();
    // R2: rising edge, then level held
    violIn = 1'b1; step();
    chk("R2", int'(rdRegs[S][0]), 1);
    chk("R3", int'(rdRegs[S][1]), 0);
    repeat (4) step();
    chk("R2", int'(rdRegs[S][0]), 1);
    // R3: falling edge, rise stays sticky
    violIn = 1'b0; step();
    chk("R3", int'(rdRegs[S][1]), 1);
    chk("R2", int'(rdRegs[S][0]), 1);
    // R4: separate clears
    riseTag = "R4"; fallTag = "R4";
    wrRegs[S] = 16'h0001; step();
    chk("R4", int'(rdRegs[S][0]), 0);
    chk("R4", int'(rdRegs[S][1]), 1);
    wrRegs[S] = 16'h0002; step();
    chk("R4", int'(rdRegs[S][1]), 0);
    wrRegs[S] = 16'h0000; step();
    // R6: clear together with a new edge
    riseTag = "R6"; fallTag = "R6";
    wrRegs[S] = 16'h0003; violIn = 1'b1; step();
    chk("R6", int'(rdRegs[S][0]), 1);
    step();
    chk("R4", int'(rdRegs[S][0]), 0);
    violIn = 1'b0; step();
    chk("R6", int'(rdRegs[S][1]), 1);
    step();
    chk("R4", int'(rdRegs[S][1]), 0);
    wrRegs[S] = 16'h0000;
    riseTag = "R2"; fallTag = "R3";
    // toggling violation with random traffic
    for (int c = 0; c < 60; c++) begin
      violIn = ~violIn;
      for (int i = 0; i < N; i++) wrRegs[i] = 16'($urandom);
      if (c % 3 != 0) wrRegs[S][1:0] = 2'b00;
      step();
    end
    wrRegs = '0; violIn = 1'b0;
    repeat (3) step();
    // R7: mid-run reset with violation high
    wrRegs[5] = 16'h1234; violIn = 1'b1; step();
    rstN = 1'b0; inReset = 1'b1;
    #1;
    chk("R7", int'(rdRegs[5]), 0);
    chk("R7", int'(rdRegs[S]), 0);
    step();
    rstN = 1'b1; inReset = 1'b0;
    riseTag = "R7";
    step();
    chk("R7", int'(rdRegs[S][0]), 1);
    riseTag = "R2";
    repeat (3) step();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule